// File: doc/BRIEF.md
# Registered Bidirectional Pad Cell

This cell sits between core logic and one tristate pad driver. On the way out, one of two core data inputs is picked by a select line. It then goes through an output register to the pad data pin. On the way in, the pad data is gated by an input enable and goes through an input register. A single core-facing return bus carries the inbound value back into the core. Under a configuration bit, it can instead carry the output register contents, so that the outbound register also serves as state storage for core state machines.

Both registers are clocked only on the rising edge of a dedicated I/O clock. Each one has its own data enable and can be bypassed, which makes its path purely combinational. One global asynchronous active-low line forces both registers while it is low. A static per-cell bit decides whether that line presets them to all ones or clears them to zero. The output enable is passed to the pad driver, and a low output enable means the driver floats the pad. Drive strength and slew are left to the pad driver.

Top module: `iocell_bidir`

## Requirements
- R1: With `cfg_preset`=0, while `aset_n` is low both registers read all zeros, taking effect at once without waiting for a clock edge.
- R2: With `cfg_preset`=1, while `aset_n` is low both registers read all ones.
- R3: With `aset_n` high, the output register loads the selected core data on a rising `io_clk` edge when `ode`=1, and holds its value when `ode`=0.
- R4: With `aset_n` high, the input register loads the gated pad data on a rising `io_clk` edge when `ide`=1, and holds its value when `ide`=0.
- R5: `uo_sel`=0 selects `uo_a` as the outbound data and `uo_sel`=1 selects `uo_b`.
- R6: With `cfg_obyp`=1, `pad_out` equals the selected core data in the same cycle. With `cfg_obyp`=0, `pad_out` shows the output register.
- R7: With `cfg_ibyp`=1 and `cfg_ysel`=0, `y` equals the gated pad data in the same cycle. With `cfg_ibyp`=0 and `cfg_ysel`=0, `y` shows the input register.
- R8: `pad_oe` follows `oe`. A low `pad_oe` tells the pad driver to float the pad.
- R9: When `ie`=0, the cell sees pad data as all zeros, both on the bypass path and for input register loads.
- R10: With `cfg_ysel`=1, `y` shows the output register contents, even when the outbound path is bypassed.
- R11: While `aset_n` is held low, clock edges with `ode`=1 and `ide`=1 do not change either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | Dedicated I/O clock, rising edge |
| aset_n | input | 1 | Global asynchronous set/clear, active low |
| cfg_obyp | input | 1 | Static: bypass the output register |
| cfg_ibyp | input | 1 | Static: bypass the input register |
| cfg_preset | input | 1 | Static: 1 = async line presets, 0 = clears |
| cfg_ysel | input | 1 | Static: 0 = `y` from inbound path, 1 = from output register |
| uo_a | input | W | Core outbound data, first source |
| uo_b | input | W | Core outbound data, second source |
| uo_sel | input | 1 | Outbound source select |
| ode | input | 1 | Output register data enable |
| ide | input | 1 | Input register data enable |
| oe | input | 1 | Output enable request |
| ie | input | 1 | Input enable; 0 forces inbound data to zero |
| pad_in | input | W | Data from the pad receiver |
| pad_out | output | W | Data to the pad driver |
| pad_oe | output | 1 | Drive enable to the pad driver |
| y | output | W | Return data into the core |

## Verification
The checker tests the following on every cycle:
- the forced value of the registers while the asynchronous line is low, in both polarities;
- output-register load and hold across each clock edge;
- the combinational bypass paths;
- zero gating of inbound data.

Three behaviours need the bench's scenarios, because no single-cycle property shows them:
- that the asynchronous line acts in the middle of a cycle, before any clock edge;
- that it wins over enabled loads across several edges;
- that the input register keeps an old value through a run of disabled edges, which is seen only once `y` is switched to it.

// File: rtl/iocell_pkg.sv
// Shared types for the registered bidirectional pad cell.
package iocell_pkg;

    // Meaning of the global asynchronous line for one cell.
    typedef enum logic {
        AKIND_CLEAR  = 1'b0,
        AKIND_PRESET = 1'b1
    } akind_e;

    // Source of the core-facing return bus.
    typedef enum logic {
        YSRC_INBOUND = 1'b0,
        YSRC_OREG    = 1'b1
    } ysrc_e;

endpackage

// File: rtl/iocell_ereg.sv
// Enabled register with asynchronous force and optional bypass.
// Assumes: byp and akind are static; aset_n is active low and asynchronous.
// q is always the stored value; o is q, or d when bypassed.
module iocell_ereg
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         aset_n,
    input  akind_e       akind,
    input  logic         en,
    input  logic         byp,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] o
);

    logic [W-1:0] force_val;

    // Value taken while the asynchronous line is low.
    always_comb force_val = (akind == AKIND_PRESET) ? {W{1'b1}} : {W{1'b0}};

    // Storage: async force wins, otherwise load on enable.
    always_ff @(posedge clk or negedge aset_n) begin
        if (!aset_n)
            q <= force_val;
        else if (en)
            q <= d;
    end

    // Bypass selection.
    always_comb o = byp ? d : q;

endmodule

// File: rtl/iocell_outpath.sv
// Outbound path: two-way source select feeding the output register.
// Assumes: side cells see two routing channels, hence two sources.
module iocell_outpath
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         aset_n,
    input  akind_e       akind,
    input  logic         obyp,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         sel,
    input  logic         ode,
    output logic [W-1:0] drive,
    output logic [W-1:0] oreg_q
);

    logic [W-1:0] picked;

    // Choose the outbound source.
    always_comb picked = sel ? src_b : src_a;

    iocell_ereg #(.W(W)) u_oreg (
        .clk    (clk),
        .aset_n (aset_n),
        .akind  (akind),
        .en     (ode),
        .byp    (obyp),
        .d      (picked),
        .q      (oreg_q),
        .o      (drive)
    );

endmodule

// File: rtl/iocell_inpath.sv
// Inbound path: input-enable gating followed by the input register.
// Assumes: a low input enable means the receiver delivers zeros.
module iocell_inpath
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         aset_n,
    input  akind_e       akind,
    input  logic         ibyp,
    input  logic         ie,
    input  logic         ide,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] inbound
);

    logic [W-1:0] gated;
    logic [W-1:0] ireg_q;

    // Zero the receiver data when input is disabled.
    always_comb gated = ie ? pad_in : {W{1'b0}};

    iocell_ereg #(.W(W)) u_ireg (
        .clk    (clk),
        .aset_n (aset_n),
        .akind  (akind),
        .en     (ide),
        .byp    (ibyp),
        .d      (gated),
        .q      (ireg_q),
        .o      (inbound)
    );

endmodule

// File: rtl/iocell_bidir.sv
// Registered bidirectional pad cell: outbound and inbound paths, each
// with a bypassable enabled register on the I/O clock, a shared async
// preset/clear line, and a return mux into the core.
// Assumes: all cfg_* inputs are static while the clock runs.
module iocell_bidir
    import iocell_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         io_clk,
    input  logic         aset_n,
    input  logic         cfg_obyp,
    input  logic         cfg_ibyp,
    input  logic         cfg_preset,
    input  logic         cfg_ysel,
    input  logic [W-1:0] uo_a,
    input  logic [W-1:0] uo_b,
    input  logic         uo_sel,
    input  logic         ode,
    input  logic         ide,
    input  logic         oe,
    input  logic         ie,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic         pad_oe,
    output logic [W-1:0] y
);

    akind_e       akind;
    ysrc_e        ysrc;
    logic [W-1:0] oreg_q;
    logic [W-1:0] inbound;

    // Decode the static configuration bits.
    always_comb begin
        akind = cfg_preset ? AKIND_PRESET : AKIND_CLEAR;
        ysrc  = cfg_ysel   ? YSRC_OREG    : YSRC_INBOUND;
    end

    iocell_outpath #(.W(W)) u_out (
        .clk    (io_clk),
        .aset_n (aset_n),
        .akind  (akind),
        .obyp   (cfg_obyp),
        .src_a  (uo_a),
        .src_b  (uo_b),
        .sel    (uo_sel),
        .ode    (ode),
        .drive  (pad_out),
        .oreg_q (oreg_q)
    );

    iocell_inpath #(.W(W)) u_in (
        .clk     (io_clk),
        .aset_n  (aset_n),
        .akind   (akind),
        .ibyp    (cfg_ibyp),
        .ie      (ie),
        .ide     (ide),
        .pad_in  (pad_in),
        .inbound (inbound)
    );

    // Pad drive enable goes straight to the driver.
    always_comb pad_oe = oe;

    // Return bus into the core.
    always_comb y = (ysrc == YSRC_OREG) ? oreg_q : inbound;

endmodule

// File: rtl/iocell_bidir_chk.sv
// Assertion checker for iocell_bidir, attached by bind below.
// Immediate checks sample at the falling clock edge, when inputs are settled.
module iocell_bidir_chk #(
    parameter int W = 4
) (
    input logic         io_clk,
    input logic         aset_n,
    input logic         cfg_obyp,
    input logic         cfg_ibyp,
    input logic         cfg_preset,
    input logic         cfg_ysel,
    input logic [W-1:0] uo_a,
    input logic [W-1:0] uo_b,
    input logic         uo_sel,
    input logic         ode,
    input logic         ie,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] y
);

    logic [W-1:0] sel_data;
    always_comb sel_data = uo_sel ? uo_b : uo_a;

    // Mid-cycle checks on forced values, bypass and gating.
    always @(negedge io_clk) begin
        if (!aset_n && !cfg_preset && cfg_ysel)
            p_force_clear_r1: assert (y == '0);
        if (!aset_n && cfg_preset && cfg_ysel)
            p_force_preset_r2: assert (y == '1);
        if (cfg_obyp)
            p_out_bypass_r6: assert (pad_out == sel_data);
        if (!ie && cfg_ibyp && !cfg_ysel)
            p_ie_gate_r9: assert (y == '0);
        if (ie && cfg_ibyp && !cfg_ysel)
            p_in_bypass_r7: assert (y == pad_in);
    end

    // Output register loads on an enabled edge.
    p_oreg_load_r3: assert property (@(posedge io_clk) disable iff (!aset_n)
        (ode && !cfg_obyp) |=> (cfg_obyp || pad_out == $past(sel_data)));

    // Output register holds on a disabled edge.
    p_oreg_hold_r3: assert property (@(posedge io_clk) disable iff (!aset_n)
        (!ode && !cfg_obyp) |=> (cfg_obyp || $stable(pad_out)));

endmodule

bind iocell_bidir iocell_bidir_chk #(.W(W)) u_chk (
    .io_clk     (io_clk),
    .aset_n     (aset_n),
    .cfg_obyp   (cfg_obyp),
    .cfg_ibyp   (cfg_ibyp),
    .cfg_preset (cfg_preset),
    .cfg_ysel   (cfg_ysel),
    .uo_a       (uo_a),
    .uo_b       (uo_b),
    .uo_sel     (uo_sel),
    .ode        (ode),
    .ie         (ie),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .y          (y)
);

// File: tb/iocell_bidir_test.sv
// Bench: a behavioural model is compared on every falling edge, and
// directed scenarios tag each comparison with the requirement in play.
module iocell_bidir_test;

    localparam int W = 4;

    logic         io_clk = 1'b0;
    logic         aset_n = 1'b0;
    logic         cfg_obyp = 1'b0, cfg_ibyp = 1'b0, cfg_preset = 1'b0, cfg_ysel = 1'b1;
    logic [W-1:0] uo_a = '0, uo_b = '0, pad_in = '0;
    logic         uo_sel = 1'b0, ode = 1'b0, ide = 1'b0, oe = 1'b0, ie = 1'b0;
    logic [W-1:0] pad_out, y;
    logic         pad_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string tag = "R1";

    logic [W-1:0] m_out, m_in;

    iocell_bidir #(.W(W)) uut (
        .io_clk(io_clk), .aset_n(aset_n), .cfg_obyp(cfg_obyp), .cfg_ibyp(cfg_ibyp),
        .cfg_preset(cfg_preset), .cfg_ysel(cfg_ysel), .uo_a(uo_a), .uo_b(uo_b),
        .uo_sel(uo_sel), .ode(ode), .ide(ide), .oe(oe), .ie(ie), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .y(y)
    );

    always #4 io_clk = ~io_clk;

    function automatic logic [W-1:0] sel_data();
        return uo_sel ? uo_b : uo_a;
    endfunction

    function automatic logic [W-1:0] seen_pad();
        return ie ? pad_in : '0;
    endfunction

    // Behavioural model of the two stored values.
    always @(posedge io_clk or negedge aset_n) begin
        if (!aset_n) begin
            m_out <= cfg_preset ? '1 : '0;
            m_in  <= cfg_preset ? '1 : '0;
        end else begin
            if (ode) m_out <= sel_data();
            if (ide) m_in  <= seen_pad();
        end
    end

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison of all outputs against the model.
    always @(negedge io_clk) begin
        logic [W-1:0] e_y;
        cycles++;
        e_y = cfg_ysel ? m_out : (cfg_ibyp ? seen_pad() : m_in);
        check(tag, "pad_out", pad_out, cfg_obyp ? sel_data() : m_out);
        check(tag, "pad_oe", {{(W-1){1'b0}}, pad_oe}, {{(W-1){1'b0}}, oe});
        check(tag, "y", y, e_y);
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge io_clk);
        #1;
    endtask

    initial begin
        // R1 reset state, clear polarity.
        tag = "R1";
        cyc(3);
        check("R1", "cleared y", y, '0);
        check("R1", "cleared pad_out", pad_out, '0);
        // R2 preset polarity while the line is held low.
        tag = "R2";
        cfg_preset = 1'b1;
        cyc(2);
        check("R2", "preset y", y, '1);
        // R11 enabled loads while held low change nothing.
        tag = "R11";
        ode = 1; ide = 1; ie = 1; uo_a = 4'h5; pad_in = 4'h3;
        cyc(3);
        check("R11", "oreg held", pad_out, '1);
        cfg_ysel = 0;
        cyc(1);
        check("R11", "ireg held", y, '1);
        // Release; R3 and R5 output loads with both sources.
        aset_n = 1; cfg_ysel = 1; ode = 0; ide = 0;
        tag = "R3";
        cyc(2);
        check("R3", "hold with ode low", pad_out, '1);
        ode = 1; uo_sel = 0; uo_a = 4'hA; uo_b = 4'h6;
        cyc(1);
        check("R3", "load a", pad_out, 4'hA);
        tag = "R5";
        uo_sel = 1;
        cyc(1);
        check("R5", "load b", pad_out, 4'h6);
        ode = 0; uo_b = 4'h1;
        cyc(2);
        check("R3", "hold after load", pad_out, 4'h6);
        // R10 y returns output register.
        tag = "R10";
        check("R10", "y is oreg", y, 4'h6);
        // R4 input register.
        tag = "R4";
        cfg_ysel = 0; ide = 1; ie = 1; pad_in = 4'hC;
        cyc(1);
        check("R4", "ireg load", y, 4'hC);
        ide = 0; pad_in = 4'h2;
        cyc(3);
        check("R4", "ireg hold", y, 4'hC);
        // R9 gating on the register path.
        tag = "R9";
        ie = 0; ide = 1;
        cyc(1);
        check("R9", "gated load", y, '0);
        // R7 input bypass and R9 on the bypass path.
        tag = "R7";
        cfg_ibyp = 1; ie = 1; pad_in = 4'h9;
        #1 check("R7", "bypass y", y, 4'h9);
        ie = 0;
        #1 check("R9", "bypass gated", y, '0);
        cyc(1);
        // R6 output bypass, R10 still shows stored value.
        tag = "R6";
        cfg_obyp = 1; ode = 0; uo_sel = 0; uo_a = 4'h7;
        #1 check("R6", "bypass pad_out", pad_out, 4'h7);
        cfg_ysel = 1;
        #1 check("R10", "y oreg under bypass", y, 4'h6);
        cyc(1);
        // R8 output enable relay.
        tag = "R8";
        oe = 1;
        #1 check("R8", "pad_oe high", {3'b0, pad_oe}, 4'h1);
        oe = 0;
        #1 check("R8", "pad_oe low", {3'b0, pad_oe}, 4'h0);
        cyc(1);
        // Random traffic, registered paths.
        tag = "R3";
        cfg_obyp = 0; cfg_ibyp = 0;
        for (int i = 0; i < 200; i++) begin
            uo_a = W'($urandom); uo_b = W'($urandom); pad_in = W'($urandom);
            uo_sel = 1'($urandom); ode = 1'($urandom); ide = 1'($urandom);
            ie = 1'($urandom); oe = 1'($urandom); cfg_ysel = 1'($urandom);
            cyc(1);
        end
        // R1 mid-cycle clear before any edge.
        tag = "R1";
        cfg_preset = 0; cfg_ysel = 1; ode = 1; uo_sel = 0; uo_a = 4'hF;
        cyc(1);
        aset_n = 0;
        #1 check("R1", "async clear mid-cycle", pad_out, '0);
        cyc(2);
        check("R11", "clear held across edges", pad_out, '0);
        aset_n = 1;
        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule